// File: doc/BRIEF.md
# Window-attribute pixel format converter

This block sits on the scanout path between the framebuffer fetch and the display back end. Each stored pixel word arrives with a small window ID. The ID picks one entry of a window attribute table. That entry tells the block how to read the pixel: which packed format it uses, which 64-entry bank of the colormap to index, and whether the colormap is bypassed. The entry also carries a buffer-select bit and a gamma-disable bit. These two bits travel with the pixel to the back end, which owns gamma and buffer handling.

Pixels in direct formats are unpacked into 8-bit red, green, blue and alpha. Narrow fields are widened by copying their top bits into the vacant low bits. The two 8-bit formats index a 1024-word colormap unless the entry sets the bypass bit. Both the input and the output are valid/ready streams. A pixel is accepted in a cycle where `in_valid` and `in_ready` are both high. A result is taken in a cycle where `out_valid` and `out_ready` are both high. When the output is held off, the two-stage pipeline freezes and keeps its result stable. `in_ready` falls only when both stages are occupied. Configuration goes through a plain write port and must not be written while pixels that depend on the changed entries are in flight.

Top module: `wpc_conv`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, and every attribute entry reads as format code 0 with bank 0 and both control bits clear.
- R2: With `out_ready` held high, a pixel accepted at one clock edge appears on the output after the second edge, and one pixel is accepted every cycle with `in_ready` staying high.
- R3: While `out_valid` is high and `out_ready` is low, the output holds its value. No pixel is lost or duplicated. With the output blocked, exactly two pixels are accepted before `in_ready` falls, and `in_ready` is high whenever `out_valid` is low.
- R4: Code 0 (24-bit direct) gives red = pix[7:0], green = pix[15:8], blue = pix[23:16] and alpha = 0xFF. Code 3 (32-bit) gives the same colour fields with alpha = pix[31:24].
- R5: Code 1 (5-6-5) takes red from pix[4:0], green from pix[10:5] and blue from pix[15:11]. Each field is widened to 8 bits by appending its top bits, and alpha is 0xFF.
- R6: Code 2 (1-5-5-5) takes red from pix[4:0], green from pix[9:5] and blue from pix[14:10], each widened to 8 bits. Alpha is 0xFF when pix[15] is set and 0x00 otherwise.
- R7: Code 0xD (3-3-2 with bypass) takes red from pix[2:0], green from pix[5:3] and blue from pix[7:6], each widened by repeating its bits. Alpha is 0xFF.
- R8: Codes 9 and 0xA read colormap word (pix[7:0] + bank*64) mod 1024. That word drives red from bits [7:0], green from [15:8], blue from [23:16] and alpha from [31:24].
- R9: Code 0xE (8-bit with bypass) outputs grey: red = green = blue = pix[7:0], and alpha = 0xFF.
- R10: Bit 2 of the code, the bypass bit, has no effect on codes 0 to 3. Codes 4 to 7 decode exactly as codes 0 to 3.
- R11: Configuration writes use `cfg_addr[10]` = 1 for colormap word `cfg_addr[9:0]`. When `cfg_addr[10]` = 0, the write goes to attribute entry `cfg_addr[6:2]`, and `cfg_addr[1:0]` picks the field: 0 is the format in data[3:0], 1 is the bank in data[3:0], 2 is buffer-select in data[0], 3 is gamma-disable in data[0]. `out_buf_b` and `out_gamma_off` carry the selected entry's control bits along with the pixel.
- R12: Codes whose value with bit 2 cleared is 8 or 0xB output all-zero red, green, blue and alpha.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can accept a pixel this cycle |
| in_pix | input | 32 | Stored pixel word |
| in_wid | input | WID_W | Window ID selecting an attribute entry |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_red | output | 8 | Red component |
| out_green | output | 8 | Green component |
| out_blue | output | 8 | Blue component |
| out_alpha | output | 8 | Alpha component |
| out_buf_b | output | 1 | Buffer-select bit of the pixel's entry |
| out_gamma_off | output | 1 | Gamma-disable bit of the pixel's entry |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CMAP_AW+1 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |

## Verification
The bench targets the colormap bank wrap: bank 15 with pixel 0xFF must read word 191. A design that carried the sum into an eleventh bit, or failed to add the bank, would return the wrong palette word. It also holds the output blocked to prove the result stays frozen and that exactly two pixels get in. A pipeline that kept advancing would drop or repeat pixels, and the scoreboard would see that. Every one of the sixteen format codes is assigned to some window, so a design that let the bypass bit alter a direct format, swapped colour fields, padded narrow fields with zeros or got the 1-5-5-5 alpha wrong would mismatch the bench's model on random pixels.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  localparam int PIX_W  = 32;
  localparam int CODE_W = 4;
  localparam int BANK_W = 4;
  localparam int CH_W   = 8;
  localparam int BYPASS_BIT = 2;

  typedef enum logic [CODE_W-1:0] {
    FMT_RGB24    = 4'h0,
    FMT_RGB565   = 4'h1,
    FMT_ARGB1555 = 4'h2,
    FMT_ARGB32   = 4'h3,
    FMT_RGB332   = 4'h9,
    FMT_INDEX8   = 4'hA
  } fmt_e;

  typedef struct packed {
    logic [CODE_W-1:0] fmt;
    logic [BANK_W-1:0] bank;
    logic              buf_b;
    logic              gamma_off;
  } attr_t;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } rgba_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [CH_W-1:0] widen3(input logic [2:0] v);
    return {v, v, v[2:1]};
  endfunction

  function automatic logic [CH_W-1:0] widen2(input logic [1:0] v);
    return {v, v, v, v};
  endfunction

endpackage

// File: rtl/wpc_attr_table.sv
module wpc_attr_table
  import wpc_pkg::*;
#(
  parameter int WID_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WID_W-1:0]  wr_entry,
  input  logic [1:0]        wr_field,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [WID_W-1:0]  rd_wid,
  output attr_t             rd_attr
);

  localparam int ENTRIES = 1 << WID_W;

  attr_t ent [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    attr_t q;
    logic  hit;

    assign hit = we && (wr_entry == WID_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (hit) begin
        case (wr_field)
          2'd0:    q.fmt       <= wr_data;
          2'd1:    q.bank      <= wr_data[BANK_W-1:0];
          2'd2:    q.buf_b     <= wr_data[0];
          default: q.gamma_off <= wr_data[0];
        endcase
      end
    end

    assign ent[e] = q;
  end

  assign rd_attr = ent[rd_wid];

endmodule

// File: rtl/wpc_unpack.sv
module wpc_unpack
  import wpc_pkg::*;
#(
  parameter int CMAP_AW    = 10,
  parameter int BANK_SHIFT = 6
) (
  input  logic [PIX_W-1:0]   pix,
  input  logic [CODE_W-1:0]  fmt,
  input  logic [BANK_W-1:0]  bank,
  output rgba_t              dir,
  output logic               use_map,
  output logic [CMAP_AW-1:0] map_idx
);

  localparam logic [CH_W-1:0] OPAQUE = '1;

  logic [CODE_W-1:0] base;
  logic              bypass;

  assign bypass  = fmt[BYPASS_BIT];
  assign base    = fmt & ~(CODE_W'(1) << BYPASS_BIT);
  assign map_idx = CMAP_AW'(pix[7:0]) + (CMAP_AW'(bank) << BANK_SHIFT);

  always_comb begin
    dir     = '0;
    use_map = 1'b0;
    case (base)
      FMT_RGB24, FMT_ARGB32: begin
        dir.r = pix[7:0];
        dir.g = pix[15:8];
        dir.b = pix[23:16];
        dir.a = (base == FMT_ARGB32) ? pix[31:24] : OPAQUE;
      end
      FMT_RGB565: begin
        dir.r = widen5(pix[4:0]);
        dir.g = widen6(pix[10:5]);
        dir.b = widen5(pix[15:11]);
        dir.a = OPAQUE;
      end
      FMT_ARGB1555: begin
        dir.r = widen5(pix[4:0]);
        dir.g = widen5(pix[9:5]);
        dir.b = widen5(pix[14:10]);
        dir.a = pix[15] ? OPAQUE : '0;
      end
      FMT_RGB332: begin
        use_map = !bypass;
        dir.r   = widen3(pix[2:0]);
        dir.g   = widen3(pix[5:3]);
        dir.b   = widen2(pix[7:6]);
        dir.a   = OPAQUE;
      end
      FMT_INDEX8: begin
        use_map = !bypass;
        dir.r   = pix[7:0];
        dir.g   = pix[7:0];
        dir.b   = pix[7:0];
        dir.a   = OPAQUE;
      end
      default: begin
        dir = '0;
      end
    endcase
  end

endmodule

// File: rtl/wpc_cmap.sv
module wpc_cmap #(
  parameter int AW     = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wpc_conv.sv
module wpc_conv
  import wpc_pkg::*;
#(
  parameter int WID_W      = 5,
  parameter int CMAP_AW    = 10,
  parameter int BANK_SHIFT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_pix,
  input  logic [WID_W-1:0]   in_wid,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_red,
  output logic [7:0]         out_green,
  output logic [7:0]         out_blue,
  output logic [7:0]         out_alpha,
  output logic               out_buf_b,
  output logic               out_gamma_off,
  input  logic               cfg_we,
  input  logic [CMAP_AW:0]   cfg_addr,
  input  logic [31:0]        cfg_wdata
);

  localparam int MAP_W = $bits(rgba_t);

  // configuration decode
  logic map_sel, tab_we, map_we;
  assign map_sel = cfg_addr[CMAP_AW];
  assign tab_we  = cfg_we && !map_sel;
  assign map_we  = cfg_we && map_sel;

  attr_t rd_attr;

  wpc_attr_table #(.WID_W(WID_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tab_we),
    .wr_entry (cfg_addr[WID_W+1:2]),
    .wr_field (cfg_addr[1:0]),
    .wr_data  (cfg_wdata[CODE_W-1:0]),
    .rd_wid   (in_wid),
    .rd_attr  (rd_attr)
  );

  // flow control: stage 2 moves when empty or drained, stage 1 follows
  logic s1_valid, s2_valid, adv2;
  assign adv2     = !s2_valid || out_ready;
  assign in_ready = adv2 || !s1_valid;

  // stage 1: captured pixel and its window attributes
  logic [PIX_W-1:0] s1_pix;
  attr_t            s1_attr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        s1_valid <= 1'b0;
    else if (in_ready) s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      s1_pix  <= in_pix;
      s1_attr <= rd_attr;
    end
  end

  rgba_t              dir_px;
  logic               s1_use_map;
  logic [CMAP_AW-1:0] s1_idx;

  wpc_unpack #(.CMAP_AW(CMAP_AW), .BANK_SHIFT(BANK_SHIFT)) u_unpack (
    .pix     (s1_pix),
    .fmt     (s1_attr.fmt),
    .bank    (s1_attr.bank),
    .dir     (dir_px),
    .use_map (s1_use_map),
    .map_idx (s1_idx)
  );

  // stage 2: colormap read and direct result side by side
  logic [MAP_W-1:0] map_q;

  wpc_cmap #(.AW(CMAP_AW), .DATA_W(MAP_W)) u_cmap (
    .clk   (clk),
    .we    (map_we),
    .waddr (cfg_addr[CMAP_AW-1:0]),
    .wdata (cfg_wdata),
    .re    (adv2 && s1_valid),
    .raddr (s1_idx),
    .rdata (map_q)
  );

  rgba_t s2_dir;
  logic  s2_use_map, s2_buf_b, s2_gamma_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s2_valid <= 1'b0;
    else if (adv2) s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (adv2 && s1_valid) begin
      s2_dir       <= dir_px;
      s2_use_map   <= s1_use_map;
      s2_buf_b     <= s1_attr.buf_b;
      s2_gamma_off <= s1_attr.gamma_off;
    end
  end

  rgba_t res;
  assign res           = s2_use_map ? rgba_t'(map_q) : s2_dir;
  assign out_valid     = s2_valid;
  assign out_red       = res.r;
  assign out_green     = res.g;
  assign out_blue      = res.b;
  assign out_alpha     = res.a;
  assign out_buf_b     = s2_buf_b;
  assign out_gamma_off = s2_gamma_off;

endmodule

// File: rtl/wpc_conv_chk.sv
module wpc_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        s1_valid,
  input logic [3:0]  s1_fmt,
  input logic [31:0] dir_word
);

  // R1: the output is empty in the first cycle out of reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R2: accepted pixel followed by a ready cycle is on the output next
  p_two_cycle_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  // R3: a blocked result stays put
  p_hold_when_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R3: an empty output never blocks the input
  p_ready_when_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R5: 5-6-5 decode is opaque and widens red by top-bit copy
  p_rgb565_widen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && (s1_fmt == 4'h1 || s1_fmt == 4'h5)) |->
      (dir_word[31:24] == 8'hFF && dir_word[2:0] == dir_word[7:5]));

  // R9: bypassed 8-bit decode is opaque grey
  p_grey_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_fmt == 4'hE) |->
      (dir_word[7:0] == dir_word[15:8] && dir_word[15:8] == dir_word[23:16]
       && dir_word[31:24] == 8'hFF));

endmodule

bind wpc_conv wpc_conv_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  ({out_alpha, out_blue, out_green, out_red}),
  .s1_valid  (s1_valid),
  .s1_fmt    (s1_attr.fmt),
  .dir_word  (dir_px)
);

// File: tb/wpc_conv_test.sv
`timescale 1ns/1ps
module wpc_conv_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pix = '0;
  logic [4:0]  in_wid = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_red, out_green, out_blue, out_alpha;
  logic        out_buf_b, out_gamma_off;
  logic        cfg_we = 1'b0;
  logic [10:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;

  always #10 clk = ~clk;

  wpc_conv uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_wid(in_wid),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue), .out_alpha(out_alpha),
    .out_buf_b(out_buf_b), .out_gamma_off(out_gamma_off),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0]  m_fmt  [32];
  logic [3:0]  m_bank [32];
  logic        m_bufb [32];
  logic        m_gam  [32];
  logic [31:0] m_cmap [1024];

  logic [31:0] exp_q  [$];
  logic [1:0]  side_q [$];
  logic [3:0]  code_q [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] code, input logic [3:0] bank, input logic [31:0] p);
    logic [3:0] base;
    logic [9:0] idx;
    logic [7:0] r, g, b, a;
    base = code & 4'hB;
    idx  = 10'(p[7:0]) + {bank, 6'b0};
    r = 8'h00; g = 8'h00; b = 8'h00; a = 8'hFF;
    case (base)
      4'h0, 4'h3: begin
        r = p[7:0]; g = p[15:8]; b = p[23:16];
        if (base == 4'h3) a = p[31:24];
      end
      4'h1: begin
        r = {p[4:0], p[4:2]}; g = {p[10:5], p[10:9]}; b = {p[15:11], p[15:13]};
      end
      4'h2: begin
        r = {p[4:0], p[4:2]}; g = {p[9:5], p[9:7]}; b = {p[14:10], p[14:12]};
        a = p[15] ? 8'hFF : 8'h00;
      end
      4'h9: begin
        if (!code[2]) return m_cmap[idx];
        r = {p[2:0], p[2:0], p[2:1]}; g = {p[5:3], p[5:3], p[5:4]}; b = {4{p[7:6]}};
      end
      4'hA: begin
        if (!code[2]) return m_cmap[idx];
        r = p[7:0]; g = p[7:0]; b = p[7:0];
      end
      default: return 32'h0;
    endcase
    return {a, b, g, r};
  endfunction

  function automatic string tag_of(input logic [3:0] code);
    logic [3:0] base;
    base = code & 4'hB;
    if (code[2] && base <= 4'h3) return "R10";
    case (base)
      4'h0, 4'h3: return "R4";
      4'h1: return "R5";
      4'h2: return "R6";
      4'h9: return code[2] ? "R7" : "R8";
      4'hA: return code[2] ? "R9" : "R8";
      default: return "R12";
    endcase
  endfunction

  // one cycle: drive at the falling edge, observe after settling
  task automatic cyc(input logic iv, input logic [31:0] p, input logic [4:0] w, input logic ordy);
    logic [31:0] e;
    logic [1:0]  s;
    logic [3:0]  c;
    @(negedge clk);
    in_valid = iv; in_pix = p; in_wid = w; out_ready = ordy;
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected output", 64'({out_alpha, out_blue, out_green, out_red}), 64'h0);
      end else begin
        e = exp_q.pop_front(); s = side_q.pop_front(); c = code_q.pop_front();
        chk({out_alpha, out_blue, out_green, out_red} == e, tag_of(c),
            64'({out_alpha, out_blue, out_green, out_red}), 64'(e));
        chk({out_buf_b, out_gamma_off} == s, "R11 sideband",
            64'({out_buf_b, out_gamma_off}), 64'(s));
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(model(m_fmt[w], m_bank[w], p));
      side_q.push_back({m_bufb[w], m_gam[w]});
      code_q.push_back(m_fmt[w]);
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) cyc(1'b0, 32'h0, 5'h0, 1'b1);
    chk(exp_q.size() == 0, "R3 drain", 64'(exp_q.size()), 64'h0);
  endtask

  task automatic cfg_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_entry(input int i, input logic [3:0] f, input logic [3:0] bk, input logic bb, input logic gm);
    cfg_write({1'b0, 3'b000, 5'(i), 2'd0}, 32'(f));
    cfg_write({1'b0, 3'b000, 5'(i), 2'd1}, 32'(bk));
    cfg_write({1'b0, 3'b000, 5'(i), 2'd2}, {31'h0, bb});
    cfg_write({1'b0, 3'b000, 5'(i), 2'd3}, {31'h0, gm});
    m_fmt[i] = f; m_bank[i] = bk; m_bufb[i] = bb; m_gam[i] = gm;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) begin
      m_fmt[i] = 4'h0; m_bank[i] = 4'h0; m_bufb[i] = 1'b0; m_gam[i] = 1'b0;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'h1);

    // R1: default entry decodes as 24-bit direct, controls clear
    cyc(1'b1, 32'hA1B2C3D4, 5'd7, 1'b1);
    drain();

    // colormap contents
    for (int k = 0; k < 1024; k++) begin
      m_cmap[k] = $urandom;
      cfg_write({1'b1, 10'(k)}, m_cmap[k]);
    end

    // every code on some window (R11 address map)
    for (int i = 0; i < 32; i++)
      set_entry(i, 4'(i % 16), 4'((i * 5) % 16), i[0], i[1]);
    set_entry(31, 4'hA, 4'hF, 1'b1, 1'b0);

    // R2: latency of two edges
    drain();
    cyc(1'b1, 32'h0000_0055, 5'd3, 1'b1);
    cyc(1'b0, 32'h0, 5'd0, 1'b1);
    chk(out_valid == 1'b0, "R2 latency early", 64'(out_valid), 64'h0);
    cyc(1'b0, 32'h0, 5'd0, 1'b1);
    chk(out_valid == 1'b1, "R2 latency due", 64'(out_valid), 64'h1);
    drain();

    // R2: full throughput
    for (int k = 0; k < 20; k++) begin
      cyc(1'b1, $urandom, 5'(k), 1'b1);
      chk(in_ready == 1'b1, "R2 throughput", 64'(in_ready), 64'h1);
    end
    drain();

    // R3: blocked output
    cyc(1'b1, 32'h0000_1234, 5'd1, 1'b0);
    cyc(1'b1, 32'h00FF_8001, 5'd2, 1'b0);
    cyc(1'b1, 32'h0000_0077, 5'd3, 1'b0);
    chk(in_ready == 1'b0, "R3 full", 64'(in_ready), 64'h0);
    chk(exp_q.size() == 2, "R3 accepted", 64'(exp_q.size()), 64'h2);
    held = {out_alpha, out_blue, out_green, out_red};
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 32'h0, 5'd0, 1'b0);
      chk(out_valid && ({out_alpha, out_blue, out_green, out_red} == held), "R3 hold",
          64'({out_alpha, out_blue, out_green, out_red}), 64'(held));
    end
    drain();

    // R8: bank wrap, bank 15 with index 0xFF gives word 191
    cyc(1'b1, 32'h0000_00FF, 5'd31, 1'b1);
    cyc(1'b1, 32'h0000_0040, 5'd31, 1'b1);
    cyc(1'b1, 32'h0000_0000, 5'd31, 1'b1);
    drain();

    // R10: same pixel on codes 0..3 and 4..7
    for (int i = 0; i < 8; i++) cyc(1'b1, 32'h7E8F_C3A5, 5'(i), 1'b1);
    drain();

    // random traffic over every window
    for (int k = 0; k < 6000; k++)
      cyc(($urandom % 5) != 0, $urandom, 5'($urandom % 32), ($urandom % 4) != 0);
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule